// File: doc/BRIEF.md
# Programmable Pulse Tone Generator

This block is a single square-wave sound voice. A host writes three byte-wide registers through a plain address, data and write-strobe port. The registers set a 12-bit period value, a 3-bit duty code, a 4-bit level, a sample-mode bit and a voice-on bit.

A programmable divider counts system clocks and emits a step pulse once every F+1 clocks. Each step pulse advances a 16-position duty sequencer. While the sequencer is in its high positions, the 4-bit output carries the level value; otherwise it carries zero. The waveform therefore repeats every 16*(F+1) clocks.

In sample mode the sequencer is bypassed, and the level value appears on the output directly as a raw 4-bit sample. The voice-on bit overrides everything else: when it is clear, the output is silent and the counters are parked at their start positions.

Top module: `pulse_voice`

## Requirements
- R1: Register address 0 holds sample-mode in bit 7, duty code in bits 6..4 and level in bits 3..0. Address 1 holds period bits 7..0. Address 2 holds voice-on in bit 7 and period bits 11..8 in bits 3..0. A write to address 3 changes nothing.
- R2: After reset all register fields are zero, so the voice is off and the output is 0.
- R3: While the voice is on, the sequencer advances one position every F+1 clocks, where F is the 12-bit period value (0..4095). Position 15 wraps to position 0.
- R4: In tone mode (sample-mode 0), the output equals the level for positions 0 through D, where D is the duty code, and is 0 for positions D+1 through 15. This gives a high time of (D+1)/16 of the period.
- R5: With the voice on and sample-mode 1, the output equals the level field in the clock after the write, whatever the period value or sequencer position.
- R6: With voice-on 0, the output is 0 even when sample-mode is 1.
- R7: While the voice is off, the divider and sequencer are held at zero. Setting voice-on starts a fresh waveform at position 0 with a full F+1 clock dwell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also the divider input |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe, one write per clock |
| wrAddr | input | 2 | Register select |
| wrData | input | 8 | Register write data |
| chanOut | output | 4 | Channel output level |

## Verification
A wrong divider count stretches or shrinks every sequencer dwell. A wrong sequencer position shifts the high-to-low edge within the 16-step frame. Both therefore appear at the output within one waveform period, 16*(F+1) clocks. The bench follows whole periods for every duty code over several period values, including one whose upper period bits are set, so a mistimed edge is caught on the cycle it happens. A mode or voice-on decoding fault shows on the output in the clock right after the register write. A counter that is not cleared while the voice is off shows as a short first dwell after the voice is turned back on.

// File: rtl/pulse_voice_pkg.sv
package pulse_voice_pkg;

  // register select codes
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_FLO  = 2'd1;
  localparam logic [1:0] ADDR_FHI  = 2'd2;

  // control byte field positions
  localparam int GATE_BIT  = 7;
  localparam int DUTY_LSB  = 4;
  localparam int ON_BIT    = 7;

  // strobes from control to datapath
  typedef struct packed {
    logic stepTick;   // advance sequencer one position
    logic stepClear;  // park sequencer at position 0
  } stepCtl_t;

endpackage

// File: rtl/pulse_voice_ctrl.sv
module pulse_voice_ctrl
  import pulse_voice_pkg::*;
#(
  parameter int FREQ_W = 12,
  parameter int DUTY_W = 3,
  parameter int VOL_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [7:0]        wrData,
  output stepCtl_t          ctl,
  output logic              gateOn,
  output logic              chanOn,
  output logic [DUTY_W-1:0] dutyCode,
  output logic [VOL_W-1:0]  volume
);

  localparam int HI_W = FREQ_W - 8;

  logic [FREQ_W-1:0] freqReg;
  logic [FREQ_W-1:0] divCount;
  logic              enReg;
  logic              gateReg;
  logic [DUTY_W-1:0] dutyReg;
  logic [VOL_W-1:0]  volReg;
  logic              divDone;
  logic              hiWrite;

  // register file
  always_ff @(posedge clk) begin
    if (!rstN) begin
      freqReg <= '0;
      enReg   <= 1'b0;
      gateReg <= 1'b0;
      dutyReg <= '0;
      volReg  <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_CTRL: begin
          gateReg <= wrData[GATE_BIT];
          dutyReg <= wrData[DUTY_LSB +: DUTY_W];
          volReg  <= wrData[VOL_W-1:0];
        end
        ADDR_FLO: freqReg[7:0] <= wrData;
        ADDR_FHI: begin
          enReg              <= wrData[ON_BIT];
          freqReg[FREQ_W-1:8] <= wrData[HI_W-1:0];
        end
        default: ;
      endcase
    end
  end

  // programmable divider: dwell of F+1 clocks per step
  assign divDone = (divCount >= freqReg);

  always_ff @(posedge clk) begin
    if (!rstN || !enReg) begin
      divCount <= '0;
    end else if (divDone) begin
      divCount <= '0;
    end else begin
      divCount <= divCount + 1'b1;
    end
  end

  assign ctl.stepTick  = enReg && divDone;
  assign ctl.stepClear = !enReg;
  assign gateOn        = gateReg;
  assign chanOn        = enReg;
  assign dutyCode      = dutyReg;
  assign volume        = volReg;

  assign hiWrite = wrEn && (wrAddr == ADDR_FHI);

  // divider climbs by one between step pulses
  p_div_climb_r3: assert property (@(posedge clk) disable iff (!rstN)
    (enReg && !ctl.stepTick && !hiWrite) |=> (divCount == $past(divCount) + 1'b1));

  // divider restarts after each step pulse
  p_div_restart_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.stepTick && !hiWrite) |=> (divCount == '0));

  // parked divider while voice is off
  p_div_parked_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!enReg && !hiWrite) |=> (divCount == '0));

  // a write to the unused address leaves the registers alone
  p_unused_addr_r1: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 2'd3) |=> ($stable(freqReg) && $stable(enReg) && $stable(volReg)));

endmodule

// File: rtl/pulse_voice_dp.sv
module pulse_voice_dp
  import pulse_voice_pkg::*;
#(
  parameter int STEPS  = 16,
  parameter int DUTY_W = 3,
  parameter int VOL_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  stepCtl_t          ctl,
  input  logic              gateOn,
  input  logic              chanOn,
  input  logic [DUTY_W-1:0] dutyCode,
  input  logic [VOL_W-1:0]  volume,
  output logic [VOL_W-1:0]  chanOut
);

  localparam int STEP_W = $clog2(STEPS);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

  logic [STEP_W-1:0] stepIdx;
  logic              pulseHigh;
  logic              levelOn;

  // duty sequencer position
  always_ff @(posedge clk) begin
    if (!rstN || ctl.stepClear) begin
      stepIdx <= '0;
    end else if (ctl.stepTick) begin
      stepIdx <= (stepIdx == LAST_STEP) ? '0 : stepIdx + 1'b1;
    end
  end

  assign pulseHigh = (stepIdx <= STEP_W'(dutyCode));

  // voice-on beats sample mode, sample mode beats the sequencer
  always_comb begin
    if (!chanOn)      levelOn = 1'b0;
    else if (gateOn)  levelOn = 1'b1;
    else              levelOn = pulseHigh;
  end

  assign chanOut = levelOn ? volume : '0;

  p_off_silent_r6: assert property (@(posedge clk) disable iff (!rstN)
    !chanOn |-> (chanOut == '0));

  p_sample_pass_r5: assert property (@(posedge clk) disable iff (!rstN)
    (chanOn && gateOn) |-> (chanOut == volume));

  p_step_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.stepTick && !ctl.stepClear && stepIdx == LAST_STEP) |=> (stepIdx == '0));

  p_step_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.stepTick && !ctl.stepClear) |=> $stable(stepIdx));

  p_step_park_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.stepClear |=> (stepIdx == '0));

  p_tone_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    (chanOn && !gateOn && stepIdx > STEP_W'(dutyCode)) |-> (chanOut == '0));

endmodule

// File: rtl/pulse_voice.sv
module pulse_voice
  import pulse_voice_pkg::*;
#(
  parameter int FREQ_W = 12,
  parameter int STEPS  = 16,
  parameter int DUTY_W = 3,
  parameter int VOL_W  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [7:0]       wrData,
  output logic [VOL_W-1:0] chanOut
);

  stepCtl_t          ctl;
  logic              gateOn;
  logic              chanOn;
  logic [DUTY_W-1:0] dutyCode;
  logic [VOL_W-1:0]  volume;

  pulse_voice_ctrl #(
    .FREQ_W(FREQ_W),
    .DUTY_W(DUTY_W),
    .VOL_W (VOL_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .ctl     (ctl),
    .gateOn  (gateOn),
    .chanOn  (chanOn),
    .dutyCode(dutyCode),
    .volume  (volume)
  );

  pulse_voice_dp #(
    .STEPS (STEPS),
    .DUTY_W(DUTY_W),
    .VOL_W (VOL_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .gateOn  (gateOn),
    .chanOn  (chanOn),
    .dutyCode(dutyCode),
    .volume  (volume),
    .chanOut (chanOut)
  );

endmodule

// File: tb/sim_pulse_voice.sv
`timescale 1ns/1ps
module sim_pulse_voice;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [3:0] chanOut;

  int testCount = 0;
  int failCount = 0;

  always #10 clk = ~clk;

  pulse_voice u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .chanOut(chanOut)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // follow a waveform from its fresh start (sample 0 = first clock after enable)
  task automatic runWave(input string req, input int f, input int d, input int v, input int n);
    for (int j = 0; j < n; j++) begin
      int pos;
      pos = (j / (f + 1)) % 16;
      check(req, chanOut, (pos <= d) ? 4'(v) : 4'd0);
      @(negedge clk);
    end
  endtask

  task automatic holdLevel(input string req, input logic [3:0] exp, input int n);
    for (int j = 0; j < n; j++) begin
      check(req, chanOut, exp);
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 20);
    failCount++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R2: reset state is silent
    holdLevel("R2 reset", 4'd0, 4);
    // R2: voice-on resets to 0, so sample mode alone stays silent
    wr(2'd0, 8'h89);
    holdLevel("R2 voice off after reset", 4'd0, 4);

    // R3 R4 R1: sweep duty codes over several period values
    for (int fi = 0; fi < 4; fi++) begin
      int f;
      f = (fi == 0) ? 0 : (fi == 1) ? 1 : (fi == 2) ? 2 : 5;
      for (int d = 0; d < 8; d++) begin
        int v;
        v = 15 - d;
        wr(2'd2, 8'h00);
        wr(2'd0, 8'((d << 4) | v));
        wr(2'd1, 8'(f));
        wr(2'd2, 8'h80);
        runWave("R4 duty sweep", f, d, v, 32 * (f + 1));
      end
    end

    // R1 R3: period value using its upper bits (0x103 -> dwell 260)
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h27);
    wr(2'd1, 8'h03);
    wr(2'd2, 8'h81);
    runWave("R3 wide period", 259, 2, 7, 16 * 260);

    // R5: sample mode passes the level through at once
    wr(2'd1, 8'h07);
    wr(2'd2, 8'h80);
    for (int v = 0; v < 16; v++) begin
      wr(2'd0, 8'(8'h80 | v));
      holdLevel("R5 sample mode", 4'(v), 5);
    end

    // R1: unused address has no effect
    wr(2'd3, 8'h00);
    holdLevel("R1 unused address", 4'd15, 6);
    wr(2'd3, 8'h7F);
    holdLevel("R1 unused address", 4'd15, 6);

    // R6: voice off overrides sample mode
    wr(2'd2, 8'h00);
    holdLevel("R6 off beats sample", 4'd0, 10);

    // R7: park while off, fresh start on re-enable
    wr(2'd0, 8'h3A);
    wr(2'd1, 8'h02);
    wr(2'd2, 8'h80);
    runWave("R7 before pause", 2, 3, 10, 20);
    wr(2'd2, 8'h00);
    holdLevel("R7 paused", 4'd0, 37);
    wr(2'd2, 8'h80);
    runWave("R7 fresh restart", 2, 3, 10, 48);

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule